// File: doc/BRIEF.md
# VME A24/D16 slave to on-board register bus bridge

This block turns qualified VME slave cycles into cycles on a simple synchronous register bus inside the board. The VME side arrives as signals that have already been synchronised to the bridge clock. A cycle counts only when it meets three conditions. It must carry one of the two standard data address modifiers. It must be a 16-bit transfer, with both data strobes low and LWORD high. Its upper seven address bits must match the board's geographic address.

When DS1 falls, the address, the address modifier, the direction and the write data are captured. The captured address then stays frozen until the next DS1 fall. Two captured address bits choose one of three active-low target selects: two FPGA targets and the bridge's own register block. A fourth code selects nothing, but that cycle is still acknowledged. A write holds address, data, direction and select steady for a setup window, pulses the write strobe for a strobe window, holds everything for a hold window, and then raises DTACK. A read waits a fixed response window, captures the returned data, presents it on the VME side and raises DTACK. After every cycle the local bus falls back to fixed idle levels.

Top module: `vme_lbus_bridge`

## Requirements
- R1: A cycle is qualified only if, at the DS1 falling edge, the address modifier is 0x39 or 0x3D, LWORD is high and DS0 is low; any other cycle drives no select and never asserts DTACK.
- R2: The address holding register loads address bits 23..1 only on a DS1 falling edge; `lb_addr` carries held bits 16..1 (lb_addr[0] = A1) and does not change at any other time.
- R3: Held address bits 23..17 must equal `geo_addr`; on a mismatch the cycle is ignored (no select, no DTACK).
- R4: Held bits A16,A15 pick the target: 00 drives lb_sel_n[0] low, 01 drives lb_sel_n[1] low, 10 drives lb_sel_n[2] low, 11 drives none; at most one select is low at any time.
- R5: A cycle that is not aimed at this board never drives any select low.
- R6: On a qualified write, `lb_dir` is low and the select, address and data are stable for WIN_CYC cycles before `lb_wstrb_n` falls, the strobe stays low for exactly WIN_CYC cycles, and everything stays unchanged for WIN_CYC cycles after the strobe rises.
- R7: On a qualified read, `lb_dir` stays high, the strobe never pulses, the select stays low for RD_WAIT_CYC cycles, and the data the target returned is then driven on `vme_rdata` with `vme_rdata_oe` high while DTACK is low.
- R8: DTACK goes low for every qualified cycle aimed at the board, including target code 11. It goes high again, together with `vme_rdata_oe`, one cycle after both data strobes are seen high.
- R9: At reset and between cycles: lb_sel_n all ones, lb_dir = 1, lb_wstrb_n = 1, lb_wdata_oe = 0, lb_wdata = all ones, vme_dtack_n = 1, vme_rdata_oe = 0.
- R10: During a write, `lb_wdata` equals the VME data captured at the DS1 fall, and `lb_wdata_oe` is high from setup through hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| geo_addr | input | GEO_W | Board geographic address |
| vme_addr | input | ADDR_HI | VME address bits ADDR_HI..1 |
| vme_am | input | 6 | Address modifier |
| vme_write_n | input | 1 | Low for a VME write |
| vme_lword_n | input | 1 | Long-word indicator, must be high |
| vme_ds0_n | input | 1 | Data strobe 0, active low |
| vme_ds1_n | input | 1 | Data strobe 1, active low |
| vme_wdata | input | DW | VME write data |
| vme_rdata | output | DW | Read data returned to VME |
| vme_rdata_oe | output | 1 | Read data valid/drive enable |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| lb_addr | output | LB_AW | Held address bits LB_AW..1 |
| lb_wdata | output | DW | Local bus data driven by the bridge |
| lb_wdata_oe | output | 1 | Bridge drive enable for local data |
| lb_rdata | input | DW | Local bus data seen by the bridge |
| lb_sel_n | output | NUM_TGT | Active-low target selects |
| lb_dir | output | 1 | Low for write, high for read |
| lb_wstrb_n | output | 1 | Active-low write strobe |

## Verification
The bench builds the bridge with WIN_CYC = 3 and RD_WAIT_CYC = 2, at the defaults for widths and target count, and uses geographic address 0x2A. With short windows, every write and read walks the whole setup, strobe, hold and response sequence within a few dozen cycles. That leaves room to count each window exactly and to check a dozen qualified and rejected cycles side by side. Directed runs then change the VME address while DS1 is held low, and assert reset in the middle of a strobe.

// File: rtl/vlb_pkg.sv
package vlb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_HOLD,
    ST_RDWAIT,
    ST_ACK,
    ST_SKIP
  } vlb_state_e;

  localparam logic [5:0] AM_USER_DATA  = 6'h39;
  localparam logic [5:0] AM_SUPER_DATA = 6'h3D;

endpackage

// File: rtl/vlb_addr_latch.sv
module vlb_addr_latch #(
  parameter int ADDR_HI = 23,
  parameter int DW      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_HI:1]   vme_addr,
  input  logic [5:0]         vme_am,
  input  logic               vme_write_n,
  input  logic               vme_lword_n,
  input  logic               vme_ds0_n,
  input  logic               vme_ds1_n,
  input  logic [DW-1:0]      vme_wdata,
  output logic [ADDR_HI:1]   addr_q,
  output logic [5:0]         am_q,
  output logic               wr_q,
  output logic               lword_n_q,
  output logic               ds0_n_q,
  output logic [DW-1:0]      wdata_q,
  output logic               start_q
);

  logic ds1_q;
  logic cap_en;

  // capture enable: DS1 seen high last cycle and low now
  assign cap_en = ds1_q & ~vme_ds1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds1_q   <= 1'b1;
      start_q <= 1'b0;
    end else begin
      ds1_q   <= vme_ds1_n;
      start_q <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      am_q      <= '0;
      wr_q      <= 1'b0;
      lword_n_q <= 1'b1;
      ds0_n_q   <= 1'b1;
      wdata_q   <= '0;
    end else if (cap_en) begin
      addr_q    <= vme_addr;
      am_q      <= vme_am;
      wr_q      <= ~vme_write_n;
      lword_n_q <= vme_lword_n;
      ds0_n_q   <= vme_ds0_n;
      wdata_q   <= vme_wdata;
    end
  end

  // R2: the held address moves only on a DS1 falling edge
  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(ds1_q && !vme_ds1_n) |=> $stable(addr_q));

endmodule

// File: rtl/vlb_decode.sv
module vlb_decode import vlb_pkg::*; #(
  parameter int GEO_W   = 7,
  parameter int NUM_TGT = 3,
  parameter int CODE_W  = 2
) (
  input  logic [5:0]         am_q,
  input  logic               lword_n_q,
  input  logic               ds0_n_q,
  input  logic [GEO_W-1:0]   geo_field,
  input  logic [GEO_W-1:0]   geo_addr,
  input  logic [CODE_W-1:0]  tgt_code,
  output logic               hit,
  output logic [NUM_TGT-1:0] tgt_sel_n
);

  logic am_ok;
  logic width_ok;
  logic geo_ok;

  assign am_ok    = (am_q == AM_USER_DATA) || (am_q == AM_SUPER_DATA);
  assign width_ok = lword_n_q & ~ds0_n_q;
  assign geo_ok   = (geo_field == geo_addr);
  assign hit      = am_ok & width_ok & geo_ok;

  // one comparator per target; codes at or above NUM_TGT select nothing
  for (genvar k = 0; k < NUM_TGT; k++) begin : g_tsel
    assign tgt_sel_n[k] = ~(tgt_code == CODE_W'(k));
  end

endmodule

// File: rtl/vlb_seq.sv
module vlb_seq import vlb_pkg::*; #(
  parameter int DW          = 16,
  parameter int NUM_TGT     = 3,
  parameter int WIN_CYC     = 4,
  parameter int RD_WAIT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               hit,
  input  logic               wr,
  input  logic [NUM_TGT-1:0] tgt_sel_n,
  input  logic [DW-1:0]      wdata,
  input  logic [DW-1:0]      lb_rdata,
  input  logic               ds0_n,
  input  logic               ds1_n,
  output logic [NUM_TGT-1:0] lb_sel_n,
  output logic               lb_dir,
  output logic               lb_wstrb_n,
  output logic [DW-1:0]      lb_wdata,
  output logic               lb_wdata_oe,
  output logic               vme_dtack_n,
  output logic [DW-1:0]      vme_rdata,
  output logic               vme_rdata_oe
);

  localparam int MAXC = (WIN_CYC > RD_WAIT_CYC) ? WIN_CYC : RD_WAIT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  vlb_state_e      st_q, st_nxt;
  logic [CW-1:0]   cnt_q, cnt_nxt;
  logic [DW-1:0]   rdata_q;
  logic            rd_cap;
  logic            strobes_off;
  logic            drv_w, drv_r;

  assign strobes_off = ds0_n & ds1_n;

  always_comb begin
    st_nxt = st_q;
    rd_cap = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!hit)    st_nxt = ST_SKIP;
          else if (wr) st_nxt = ST_SETUP;
          else         st_nxt = ST_RDWAIT;
        end
      end
      ST_SETUP:  if (cnt_q == CW'(WIN_CYC - 1)) st_nxt = ST_STRB;
      ST_STRB:   if (cnt_q == CW'(WIN_CYC - 1)) st_nxt = ST_HOLD;
      ST_HOLD:   if (cnt_q == CW'(WIN_CYC - 1)) st_nxt = ST_ACK;
      ST_RDWAIT: begin
        if (cnt_q == CW'(RD_WAIT_CYC - 1)) begin
          st_nxt = ST_ACK;
          rd_cap = 1'b1;
        end
      end
      ST_ACK:  if (strobes_off) st_nxt = ST_IDLE;
      ST_SKIP: if (strobes_off) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_nxt != st_q) cnt_nxt = '0;
    else                cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= lb_rdata;
  end

  assign drv_w = (st_q == ST_SETUP) || (st_q == ST_STRB) || (st_q == ST_HOLD);
  assign drv_r = (st_q == ST_RDWAIT);

  assign lb_sel_n     = (drv_w || drv_r) ? tgt_sel_n : '1;
  assign lb_dir       = ~drv_w;
  assign lb_wstrb_n   = ~(st_q == ST_STRB);
  assign lb_wdata_oe  = drv_w;
  assign lb_wdata     = drv_w ? wdata : '1;
  assign vme_dtack_n  = ~(st_q == ST_ACK);
  assign vme_rdata_oe = (st_q == ST_ACK) && !wr;
  assign vme_rdata    = vme_rdata_oe ? rdata_q : '0;

  // checker state: strobe pulse length and previous strobe level
  logic [CW-1:0] strb_len_q;
  logic          wstrb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_len_q <= '0;
      wstrb_q    <= 1'b1;
    end else begin
      wstrb_q    <= lb_wstrb_n;
      strb_len_q <= lb_wstrb_n ? '0 : strb_len_q + CW'(1);
    end
  end

  // R4: never two selects low together
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~lb_sel_n));

  // R5: a rejected cycle keeps every select high
  a_r5_skip_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> (&lb_sel_n && vme_dtack_n));

  // R6: select, direction and data already settled when the strobe falls
  a_r6_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lb_wstrb_n) |-> ($stable(lb_sel_n) && $stable(lb_dir) && $stable(lb_wdata)));

  // R6: strobe low for exactly the window length
  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!wstrb_q && lb_wstrb_n) |-> (strb_len_q == CW'(WIN_CYC)));

  // R6: hold window still driving when the strobe rises
  a_r6_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lb_wstrb_n) |-> (!lb_dir && lb_wdata_oe));

  // R7: a strobe only ever happens with direction set to write
  a_r7_no_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_wstrb_n |-> !lb_dir);

  // R8: acknowledge released once both strobes are up
  a_r8_dtack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!vme_dtack_n && ds0_n && ds1_n) |=> (vme_dtack_n && !vme_rdata_oe));

  // R9: idle levels while no cycle runs
  a_r9_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (&lb_sel_n && lb_dir && lb_wstrb_n && !lb_wdata_oe && vme_dtack_n));

endmodule

// File: rtl/vme_lbus_bridge.sv
module vme_lbus_bridge #(
  parameter int ADDR_HI     = 23,
  parameter int GEO_W       = 7,
  parameter int LB_AW       = 16,
  parameter int DW          = 16,
  parameter int NUM_TGT     = 3,
  parameter int WIN_CYC     = 4,
  parameter int RD_WAIT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GEO_W-1:0]   geo_addr,
  input  logic [ADDR_HI:1]   vme_addr,
  input  logic [5:0]         vme_am,
  input  logic               vme_write_n,
  input  logic               vme_lword_n,
  input  logic               vme_ds0_n,
  input  logic               vme_ds1_n,
  input  logic [DW-1:0]      vme_wdata,
  output logic [DW-1:0]      vme_rdata,
  output logic               vme_rdata_oe,
  output logic               vme_dtack_n,
  output logic [LB_AW-1:0]   lb_addr,
  output logic [DW-1:0]      lb_wdata,
  output logic               lb_wdata_oe,
  input  logic [DW-1:0]      lb_rdata,
  output logic [NUM_TGT-1:0] lb_sel_n,
  output logic               lb_dir,
  output logic               lb_wstrb_n
);

  localparam int CODE_W = $clog2(NUM_TGT + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_HI:1]   addr_q;
  logic [5:0]         am_q;
  logic               wr_q, lword_n_q, ds0_n_q, start_q;
  logic [DW-1:0]      wdata_q;
  logic               hit;
  logic [NUM_TGT-1:0] tgt_sel_n;

  vlb_addr_latch #(.ADDR_HI(ADDR_HI), .DW(DW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .vme_addr   (vme_addr),
    .vme_am     (vme_am),
    .vme_write_n(vme_write_n),
    .vme_lword_n(vme_lword_n),
    .vme_ds0_n  (vme_ds0_n),
    .vme_ds1_n  (vme_ds1_n),
    .vme_wdata  (vme_wdata),
    .addr_q     (addr_q),
    .am_q       (am_q),
    .wr_q       (wr_q),
    .lword_n_q  (lword_n_q),
    .ds0_n_q    (ds0_n_q),
    .wdata_q    (wdata_q),
    .start_q    (start_q)
  );

  vlb_decode #(.GEO_W(GEO_W), .NUM_TGT(NUM_TGT), .CODE_W(CODE_W)) u_decode (
    .am_q      (am_q),
    .lword_n_q (lword_n_q),
    .ds0_n_q   (ds0_n_q),
    .geo_field (addr_q[ADDR_HI -: GEO_W]),
    .geo_addr  (geo_addr),
    .tgt_code  (addr_q[LB_AW -: CODE_W]),
    .hit       (hit),
    .tgt_sel_n (tgt_sel_n)
  );

  vlb_seq #(.DW(DW), .NUM_TGT(NUM_TGT), .WIN_CYC(WIN_CYC), .RD_WAIT_CYC(RD_WAIT_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start_q),
    .hit         (hit),
    .wr          (wr_q),
    .tgt_sel_n   (tgt_sel_n),
    .wdata       (wdata_q),
    .lb_rdata    (lb_rdata),
    .ds0_n       (vme_ds0_n),
    .ds1_n       (vme_ds1_n),
    .lb_sel_n    (lb_sel_n),
    .lb_dir      (lb_dir),
    .lb_wstrb_n  (lb_wstrb_n),
    .lb_wdata    (lb_wdata),
    .lb_wdata_oe (lb_wdata_oe),
    .vme_dtack_n (vme_dtack_n),
    .vme_rdata   (vme_rdata),
    .vme_rdata_oe(vme_rdata_oe)
  );

  assign lb_addr = addr_q[LB_AW:1];

endmodule

// File: tb/vme_lbus_bridge_tb_top.sv
module vme_lbus_bridge_tb_top;

  localparam int  WIN  = 3;
  localparam int  RDW  = 2;
  localparam time TCLK = 5ns;
  localparam logic [6:0] GEO = 7'h2A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:1] vme_addr;
  logic [5:0]  vme_am;
  logic        vme_write_n, vme_lword_n, vme_ds0_n, vme_ds1_n;
  logic [15:0] vme_wdata, vme_rdata;
  logic        vme_rdata_oe, vme_dtack_n;
  logic [15:0] lb_addr, lb_wdata, lb_rdata;
  logic        lb_wdata_oe, lb_dir, lb_wstrb_n;
  logic [2:0]  lb_sel_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  vme_lbus_bridge #(.WIN_CYC(WIN), .RD_WAIT_CYC(RDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .geo_addr(GEO),
    .vme_addr(vme_addr), .vme_am(vme_am), .vme_write_n(vme_write_n),
    .vme_lword_n(vme_lword_n), .vme_ds0_n(vme_ds0_n), .vme_ds1_n(vme_ds1_n),
    .vme_wdata(vme_wdata), .vme_rdata(vme_rdata), .vme_rdata_oe(vme_rdata_oe),
    .vme_dtack_n(vme_dtack_n), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
    .lb_wdata_oe(lb_wdata_oe), .lb_rdata(lb_rdata), .lb_sel_n(lb_sel_n),
    .lb_dir(lb_dir), .lb_wstrb_n(lb_wstrb_n)
  );

  // target model: each selected target answers a read with its tag xor address
  assign lb_rdata = !lb_dir      ? 16'hFFFF :
                    !lb_sel_n[0] ? (16'hA000 ^ lb_addr) :
                    !lb_sel_n[1] ? (16'hB000 ^ lb_addr) :
                    !lb_sel_n[2] ? (16'hC000 ^ lb_addr) : 16'hFFFF;

  typedef struct packed {
    logic [5:0]  am;
    logic [23:0] addr;
    logic        wr;
    logic [15:0] wd;
    logic        lword_n;
    logic        ds0_n;
    logic        ack;
    logic [2:0]  sel_n;
    logic [1:0]  why;   // 0 aimed at board, 1 modifier/width reject, 2 geo reject
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{6'h39, 24'h540024, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b1, 3'b110, 2'd0},
    '{6'h3D, 24'h548010, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 3'b101, 2'd0},
    '{6'h39, 24'h550100, 1'b1, 16'hBEEF, 1'b1, 1'b0, 1'b1, 3'b011, 2'd0},
    '{6'h3D, 24'h558002, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 3'b111, 2'd0},
    '{6'h39, 24'h547FFE, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 3'b110, 2'd0},
    '{6'h3D, 24'h55800A, 1'b1, 16'h0F0F, 1'b1, 1'b0, 1'b1, 3'b111, 2'd0},
    '{6'h09, 24'h540010, 1'b1, 16'h1111, 1'b1, 1'b0, 1'b0, 3'b111, 2'd1},
    '{6'h3E, 24'h548010, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 3'b111, 2'd1},
    '{6'h39, 24'h560010, 1'b1, 16'h2222, 1'b1, 1'b0, 1'b0, 3'b111, 2'd2},
    '{6'h39, 24'h540010, 1'b1, 16'h3333, 1'b0, 1'b0, 1'b0, 3'b111, 2'd1},
    '{6'h3D, 24'h548010, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 3'b111, 2'd1}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [23:0] a, input logic [2:0] s);
    case (s)
      3'b110:  return 16'hA000 ^ a[16:1];
      3'b101:  return 16'hB000 ^ a[16:1];
      3'b011:  return 16'hC000 ^ a[16:1];
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R9 sel idle"},    {29'd0, lb_sel_n}, 32'h7);
    chk({tag, " R9 dir idle"},    {31'd0, lb_dir}, 32'h1);
    chk({tag, " R9 strobe idle"}, {31'd0, lb_wstrb_n}, 32'h1);
    chk({tag, " R9 data idle"},   {15'd0, lb_wdata_oe, lb_wdata}, 32'h0FFFF);
    chk({tag, " R8 dtack idle"},  {30'd0, vme_dtack_n, vme_rdata_oe}, 32'h2);
  endtask

  task automatic start_cycle(input vec_t v);
    vme_am      = v.am;
    vme_addr    = v.addr[23:1];
    vme_write_n = ~v.wr;
    vme_wdata   = v.wd;
    vme_lword_n = v.lword_n;
    vme_ds0_n   = v.ds0_n;
    vme_ds1_n   = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    vec_t v = VECS[idx];
    int pre = 0, strb = 0, post = 0, selc = 0;
    bit started = 0, got_ack = 0, any_sel = 0, read_strb = 0, dirlow = 0;
    logic [2:0]  seen_sel = 3'b111;
    logic [15:0] cap_d = '0, cap_a = '0, ack_d = '0;
    logic        cap_oe = 1'b0, ack_oe = 1'b0;
    string tag;
    tag = $sformatf("vec%0d", idx);
    @(negedge clk);
    start_cycle(v);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (lb_sel_n != 3'b111) begin any_sel = 1; seen_sel = lb_sel_n; selc++; end
      if (!lb_dir) begin
        dirlow = 1;
        if (lb_wstrb_n && !started) pre++;
        else if (lb_wstrb_n) post++;
      end
      if (!lb_wstrb_n) begin
        if (lb_dir) read_strb = 1;
        if (!started) begin cap_d = lb_wdata; cap_oe = lb_wdata_oe; cap_a = lb_addr; end
        started = 1; strb++;
      end
      if (!vme_dtack_n) begin got_ack = 1; ack_d = vme_rdata; ack_oe = vme_rdata_oe; break; end
    end
    vme_ds0_n = 1'b1;
    vme_ds1_n = 1'b1;
    if (v.ack) chk({tag, " R8 dtack for aimed cycle"}, {31'd0, got_ack}, 32'h1);
    else begin
      case (v.why)
        2'd1:    chk({tag, " R1 rejected modifier/width no dtack"}, {31'd0, got_ack}, 32'h0);
        default: chk({tag, " R3 geo mismatch no dtack"}, {31'd0, got_ack}, 32'h0);
      endcase
      chk({tag, " R5 no select when not aimed"}, {31'd0, any_sel}, 32'h0);
    end
    if (v.ack) begin
      chk({tag, " R4 target select"}, {29'd0, seen_sel}, {29'd0, v.sel_n});
      if (v.wr) begin
        chk({tag, " R6 setup cycles"},  pre,  WIN);
        chk({tag, " R6 strobe cycles"}, strb, WIN);
        chk({tag, " R6 hold cycles"},   post, WIN);
        chk({tag, " R10 write data"},   {15'd0, cap_oe, cap_d}, {15'd0, 1'b1, v.wd});
        chk({tag, " R2 address on bus"}, {16'd0, cap_a}, {16'd0, v.addr[16:1]});
      end else begin
        chk({tag, " R7 no strobe/dir on read"}, {30'd0, read_strb, dirlow}, 32'h0);
        if (v.sel_n != 3'b111) chk({tag, " R7 response window"}, selc, RDW);
        chk({tag, " R7 read data"}, {15'd0, ack_oe, ack_d}, {15'd0, 1'b1, exp_rd(v.addr, v.sel_n)});
      end
    end
    @(negedge clk);
    check_idle(tag);
  endtask

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    logic [15:0] held;
    rst_n = 1'b0;
    vme_addr = '0; vme_am = '0; vme_write_n = 1'b1; vme_lword_n = 1'b1;
    vme_ds0_n = 1'b1; vme_ds1_n = 1'b1; vme_wdata = '0;
    repeat (3) @(negedge clk);
    check_idle("reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("post-reset");

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: address changes while DS1 stays low do not reach the held address
    v = VECS[1];
    @(negedge clk);
    start_cycle(v);
    repeat (2) @(negedge clk);
    vme_addr = 23'h7FFFFF;
    @(negedge clk);
    chk("R2 addr frozen while DS1 low", {16'd0, lb_addr}, {16'd0, v.addr[16:1]});
    for (int c = 0; c < 30 && vme_dtack_n; c++) @(negedge clk);
    chk("R8 dtack after frozen-addr read", {31'd0, vme_dtack_n}, 32'h0);
    vme_ds0_n = 1'b1; vme_ds1_n = 1'b1;
    @(negedge clk);
    chk("R8 dtack released one cycle after strobes high", {31'd0, vme_dtack_n}, 32'h1);
    held = lb_addr;
    vme_addr = 23'h123456;
    repeat (3) @(negedge clk);
    chk("R2 addr unchanged with strobes high", {16'd0, lb_addr}, {16'd0, held});

    // reset in the middle of a write strobe returns the bus to idle
    v = VECS[0];
    @(negedge clk);
    start_cycle(v);
    for (int c = 0; c < 30 && lb_wstrb_n; c++) @(negedge clk);
    chk("R6 strobe reached before reset", {31'd0, lb_wstrb_n}, 32'h0);
    rst_n = 1'b0;
    #1;
    check_idle("mid-strobe reset");
    vme_ds0_n = 1'b1; vme_ds1_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("after mid-strobe reset");

    // a follow-up write works normally after the reset
    run_vec(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule